// File: doc/BRIEF.md
# Endpoint Byte Count and Status Register

This block holds the per-endpoint count-and-status byte that firmware and the USB serial interface engine both use. Before an IN transfer, firmware writes the number of bytes to send together with the data-toggle value. When an OUT or SETUP packet has been received, the engine overwrites the byte. The new value holds the received toggle, a data-valid flag that follows the CRC result, and a byte count that includes the two CRC bytes.

The stored byte is always visible on the read port. The IN packet builder gets a count that never exceeds the endpoint's payload limit, along with the toggle to send. Each hardware update is followed by a single-cycle endpoint interrupt pulse. The pulse fires even when the CRC was bad. CRC computation, FIFO storage and the transmitter belong to other blocks.

Top module: `ep_count_reg`

## Requirements
- R1: While `rst_n` is low, and after it is released, `reg_value` is 0x00, `ep_irq` is 0, `tx_count_err` is 0 and `tx_count` is 0.
- R2: The register fields are bit 7 = toggle (0 = DATA0, 1 = DATA1), bit 6 = data valid, bits 5..0 = byte count. `tx_toggle` always equals bit 7.
- R3: A cycle with `cpu_wr` high and `rx_done` low loads `cpu_wdata` into the whole register, visible on `reg_value` after that clock edge.
- R4: A cycle with `rx_done` high sets bits 5..0 to `rx_bytes` + 2. A `rx_bytes` value above 32 is treated as 32, which gives 34.
- R5: On an `rx_done` update, bit 6 is set to `rx_crc_ok`: 1 for a good CRC and 0 for a bad one.
- R6: On an `rx_done` update, bit 7 is set to `rx_toggle`.
- R7: `ep_irq` is high for exactly the one cycle after the first cycle in which `reg_value` shows a hardware update. This holds whether the CRC was good or bad. A CPU write never raises `ep_irq`.
- R8: When `rx_done` and `cpu_wr` are both high in one cycle, the hardware update is stored and `cpu_wdata` is discarded.
- R9: `tx_count` equals bits 5..0 when they are 32 or less, and 32 otherwise.
- R10: A CPU write with bits 5..0 above 32 sets `tx_count_err`. A CPU write with bits 5..0 of 32 or less clears it, and so does any hardware update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write data |
| rx_done | input | 1 | End-of-receive strobe from the serial engine |
| rx_bytes | input | 6 | Data bytes received, without CRC |
| rx_crc_ok | input | 1 | Received CRC was correct |
| rx_toggle | input | 1 | Toggle bit of the received data PID |
| reg_value | output | 8 | Register contents for CPU reads |
| tx_count | output | 6 | Limited byte count for the IN packet builder |
| tx_toggle | output | 1 | Toggle for the IN packet |
| tx_count_err | output | 1 | Last CPU write held an oversize IN count |
| ep_irq | output | 1 | Single-cycle endpoint interrupt |

## Verification
The hardest case to reach is a CPU write that lands in the same cycle as an end-of-receive strobe. The bench forces it by raising both strobes before a single clock edge. It then checks that the received image is stored, that the interrupt still follows, and that the oversize-count error flag is cleared rather than set by the discarded write data. Two receive cases are also driven on purpose. One is an oversize received length, which must saturate at 34. The other is back-to-back receives, whose interrupt pulses must line up cycle for cycle.

// File: rtl/ep_count_pkg.sv
package ep_count_pkg;
    localparam int unsigned REG_W = 8;

    typedef struct packed {
        logic [REG_W-1:0] regv;
        logic             pend;
        logic             irq;
        logic             err;
    } epc_state_t;
endpackage

// File: rtl/epc_rx_image.sv
module epc_rx_image #(
    parameter int unsigned CNT_W     = 6,
    parameter int unsigned RX_MAX    = 32,
    parameter int unsigned CRC_BYTES = 2
) (
    input  logic [CNT_W-1:0] rx_bytes,
    input  logic             rx_crc_ok,
    input  logic             rx_toggle,
    output logic [CNT_W+1:0] image
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(RX_MAX);
    localparam logic [CNT_W-1:0] EXTRA = CNT_W'(CRC_BYTES);

    logic [CNT_W-1:0] bounded;

    always_comb begin
        bounded = (rx_bytes > LIMIT) ? LIMIT : rx_bytes;
        image   = {rx_toggle, rx_crc_ok, bounded + EXTRA};
    end
endmodule

// File: rtl/epc_tx_view.sv
module epc_tx_view #(
    parameter int unsigned CNT_W  = 6,
    parameter int unsigned TX_MAX = 32
) (
    input  logic [CNT_W+1:0] regv,
    output logic [CNT_W-1:0] tx_count,
    output logic             tx_toggle
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TX_MAX);

    always_comb begin
        tx_count  = (regv[CNT_W-1:0] > LIMIT) ? LIMIT : regv[CNT_W-1:0];
        tx_toggle = regv[CNT_W+1];
    end
endmodule

// File: rtl/epc_over_check.sv
module epc_over_check #(
    parameter int unsigned CNT_W  = 6,
    parameter int unsigned TX_MAX = 32
) (
    input  logic [CNT_W-1:0] count,
    output logic             over
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TX_MAX);

    always_comb over = (count > LIMIT);
endmodule

// File: rtl/ep_count_reg.sv
module ep_count_reg
    import ep_count_pkg::*;
#(
    parameter int unsigned CNT_W     = 6,
    parameter int unsigned TX_MAX    = 32,
    parameter int unsigned RX_MAX    = 32,
    parameter int unsigned CRC_BYTES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_wr,
    input  logic [7:0]       cpu_wdata,
    input  logic             rx_done,
    input  logic [CNT_W-1:0] rx_bytes,
    input  logic             rx_crc_ok,
    input  logic             rx_toggle,
    output logic [7:0]       reg_value,
    output logic [CNT_W-1:0] tx_count,
    output logic             tx_toggle,
    output logic             tx_count_err,
    output logic             ep_irq
);
    localparam int unsigned DW = CNT_W + 2;

    epc_state_t       st_d, st_q;
    logic [DW-1:0]    rx_img;
    logic             wr_over;

    epc_rx_image #(.CNT_W(CNT_W), .RX_MAX(RX_MAX), .CRC_BYTES(CRC_BYTES)) u_rx (
        .rx_bytes (rx_bytes),
        .rx_crc_ok(rx_crc_ok),
        .rx_toggle(rx_toggle),
        .image    (rx_img)
    );

    epc_over_check #(.CNT_W(CNT_W), .TX_MAX(TX_MAX)) u_over (
        .count(cpu_wdata[CNT_W-1:0]),
        .over (wr_over)
    );

    epc_tx_view #(.CNT_W(CNT_W), .TX_MAX(TX_MAX)) u_tx (
        .regv     (st_q.regv[DW-1:0]),
        .tx_count (tx_count),
        .tx_toggle(tx_toggle)
    );

    // Next-state: hardware receive update outranks a CPU write.
    always_comb begin
        st_d      = st_q;
        st_d.pend = rx_done;
        st_d.irq  = st_q.pend;
        if (rx_done) begin
            st_d.regv = REG_W'(rx_img);
            st_d.err  = 1'b0;
        end else if (cpu_wr) begin
            st_d.regv = cpu_wdata;
            st_d.err  = wr_over;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign reg_value    = st_q.regv;
    assign tx_count_err = st_q.err;
    assign ep_irq       = st_q.irq;
endmodule

// File: rtl/ep_count_reg_chk.sv
module ep_count_reg_chk #(
    parameter int unsigned CNT_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cpu_wr,
    input logic [7:0]       cpu_wdata,
    input logic             rx_done,
    input logic [CNT_W-1:0] rx_bytes,
    input logic             rx_crc_ok,
    input logic             rx_toggle,
    input logic [7:0]       reg_value,
    input logic [CNT_W-1:0] tx_count,
    input logic             tx_toggle,
    input logic             tx_count_err,
    input logic             ep_irq
);
    logic [1:0] age;
    always_ff @(posedge clk) begin
        if (!rst_n) age <= '0;
        else if (age != 2'd2) age <= age + 2'd1;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (reg_value == 8'h00 && !ep_irq && !tx_count_err)); // R1
    AST_TOGGLE_OUT: assert property (@(posedge clk) disable iff (!rst_n) tx_toggle == reg_value[7]); // R2
    AST_CPU_LOAD: assert property (@(posedge clk) disable iff (!rst_n) (cpu_wr && !rx_done) |=> reg_value == $past(cpu_wdata)); // R3
    AST_RX_COUNT: assert property (@(posedge clk) disable iff (!rst_n) rx_done |=> (reg_value[5:0] >= 6'd2 && reg_value[5:0] <= 6'd34)); // R4
    AST_RX_VALID: assert property (@(posedge clk) disable iff (!rst_n) rx_done |=> reg_value[6] == $past(rx_crc_ok)); // R5
    AST_RX_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n) rx_done |=> reg_value[7] == $past(rx_toggle)); // R6
    AST_IRQ_ALIGN: assert property (@(posedge clk) disable iff (!rst_n) (age == 2'd2) |-> ep_irq == $past(rx_done, 2)); // R7
    AST_HW_WINS: assert property (@(posedge clk) disable iff (!rst_n) (rx_done && cpu_wr) |=> !tx_count_err); // R8
    AST_TX_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) tx_count <= 6'd32); // R9
    AST_OVER_FLAG: assert property (@(posedge clk) disable iff (!rst_n) (cpu_wr && !rx_done && cpu_wdata[5:0] > 6'd32) |=> tx_count_err); // R10

    logic unused_ok;
    assign unused_ok = ^rx_bytes;
endmodule

bind ep_count_reg ep_count_reg_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/ep_count_reg_test.sv
module ep_count_reg_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       cpu_wr;
    logic [7:0] cpu_wdata;
    logic       rx_done;
    logic [5:0] rx_bytes;
    logic       rx_crc_ok;
    logic       rx_toggle;
    logic [7:0] reg_value;
    logic [5:0] tx_count;
    logic       tx_toggle;
    logic       tx_count_err;
    logic       ep_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ep_count_reg uut (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] rx_exp(input logic tg, input logic ok, input int b);
        int c = (b > 32 ? 32 : b) + 2;
        return {tg, ok, 6'(c)};
    endfunction

    task automatic idle();
        cpu_wr = 0; rx_done = 0;
    endtask

    // Drive at negedge, one clock edge, then sample at the next negedge.
    task automatic cpu_write(input logic [7:0] d);
        @(negedge clk); idle(); cpu_wr = 1; cpu_wdata = d;
        @(negedge clk); idle();
    endtask

    task automatic rx(input int b, input logic ok, input logic tg);
        @(negedge clk); idle(); rx_done = 1; rx_bytes = 6'(b); rx_crc_ok = ok; rx_toggle = tg;
        @(negedge clk); idle();
    endtask

    task automatic t_reset();
        chk("R1 reg", reg_value, 0);
        chk("R1 irq", ep_irq, 0);
        chk("R1 err", tx_count_err, 0);
        chk("R1 txcnt", tx_count, 0);
    endtask

    task automatic t_cpu();
        cpu_write(8'h94);
        chk("R3 reg", reg_value, 8'h94);
        chk("R2 toggle", tx_toggle, 1);
        chk("R9 txcnt", tx_count, 20);
        chk("R10 err", tx_count_err, 0);
        chk("R7 no irq", ep_irq, 0);
        @(negedge clk);
        chk("R7 no irq later", ep_irq, 0);
        cpu_write(8'h20);
        chk("R9 txcnt 32", tx_count, 32);
        chk("R2 toggle0", tx_toggle, 0);
    endtask

    task automatic t_over();
        cpu_write(8'hA5);
        chk("R9 clamp", tx_count, 32);
        chk("R10 set", tx_count_err, 1);
        chk("R3 raw", reg_value, 8'hA5);
        cpu_write(8'h05);
        chk("R10 clear", tx_count_err, 0);
        chk("R9 small", tx_count, 5);
    endtask

    task automatic t_rx_good();
        rx(8, 1, 1);
        chk("R4 R5 R6 image", reg_value, rx_exp(1, 1, 8));
        chk("R7 not yet", ep_irq, 0);
        @(negedge clk);
        chk("R7 pulse", ep_irq, 1);
        @(negedge clk);
        chk("R7 one cycle", ep_irq, 0);
    endtask

    task automatic t_rx_bad();
        rx(0, 0, 0);
        chk("R5 bad crc", reg_value, rx_exp(0, 0, 0));
        @(negedge clk);
        chk("R7 bad crc irq", ep_irq, 1);
        @(negedge clk);
        rx(40, 1, 0);
        chk("R4 saturate", reg_value[5:0], 34);
        chk("R9 rx clamp", tx_count, 32);
        rx(32, 1, 1);
        chk("R4 max", reg_value, rx_exp(1, 1, 32));
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_collide();
        cpu_write(8'h3F);
        chk("R10 pre", tx_count_err, 1);
        @(negedge clk); idle();
        rx_done = 1; rx_bytes = 6'd3; rx_crc_ok = 1; rx_toggle = 0;
        cpu_wr = 1; cpu_wdata = 8'hFF;
        @(negedge clk); idle();
        chk("R8 hw wins", reg_value, rx_exp(0, 1, 3));
        chk("R10 hw clears", tx_count_err, 0);
        @(negedge clk);
        chk("R8 irq", ep_irq, 1);
        @(negedge clk);
    endtask

    task automatic t_b2b();
        @(negedge clk); idle();
        rx_done = 1; rx_bytes = 6'd1; rx_crc_ok = 1; rx_toggle = 1;
        @(negedge clk);
        rx_bytes = 6'd2; rx_crc_ok = 0; rx_toggle = 0;
        @(negedge clk); idle();
        chk("R4 second", reg_value, rx_exp(0, 0, 2));
        chk("R7 b2b first", ep_irq, 1);
        @(negedge clk);
        chk("R7 b2b second", ep_irq, 1);
        @(negedge clk);
        chk("R7 b2b end", ep_irq, 0);
    endtask

    initial begin
        rst_n = 0; idle(); cpu_wdata = 0; rx_bytes = 0; rx_crc_ok = 0; rx_toggle = 0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_cpu();
        t_over();
        t_rx_good();
        t_rx_bad();
        t_collide();
        t_b2b();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule